// File: doc/BRIEF.md
# Event Counter Unit

A bank of programmable event counters that sits behind a single-cycle memory-mapped register port with a 64-bit data path. Each counter picks one line out of a wide event bus using an eight-bit code and adds one on every clock in which that line is high. A counter only advances when the global run bit and its own enable bit are both set.

When a counter wraps from its all-ones value back to zero, the unit sets that counter's overflow status bit. A per-counter mask decides whether that bit contributes to the single level-sensitive interrupt line. Software clears status bits by writing ones to a dedicated clear word. It can also preload any counter so that it wraps after a chosen number of events.

Writes take effect on the clock edge where `wr_en` is high. Reads are combinational from `rd_addr`, so the value a write or a count produces can be read in the cycle after that edge.

Top module: `evt_counter_unit`

## Requirements
- R1: After reset the run bit, the enable word, every counter and every status bit are zero, the mask word is all ones (0xFFFF), every select field holds 0xFF, and `irq` is low.
- R2: Counter i is read and written as a 64-bit word at offset 0x1F00 + 8*i. Bits 47:0 hold the count, bits 63:48 always read zero, and the values written to bits 63:48 are discarded.
- R3: The code of counter i is held in bits [8*(i%4)+7 : 8*(i%4)] of the 32-bit select word at 0x1E80 + 4*(i/4). In every cycle where the counter is allowed to count and `evt_in[code]` is high, the counter increases by one.
- R4: While bit 0 of the control word at 0x1E00 is clear, no counter changes except through a direct write.
- R5: Bit i of the enable word at 0x1E04 gates counter i. With the bit clear, the counter holds its value even when its event is high.
- R6: A counter whose code is 0xFF never increments, even when `evt_in[255]` is high.
- R7: When a counter increments from 0xFFFF_FFFF_FFFF it becomes zero and sets bit i of the status word at 0x0808. This happens whether or not the interrupt of that counter is masked.
- R8: Writing to the clear word at 0x080C clears every status bit whose data bit is 1 and leaves the status bits written with 0 unchanged. If a wrap and a clear of the same bit happen in the same cycle, the bit ends up set.
- R9: `irq` is high exactly when some status bit is set whose bit in the mask word at 0x0804 is 0. A mask bit of 1 blocks that counter.
- R10: Reads of any offset outside the map return zero, and reads of the clear word also return zero. Writes to unmapped offsets and to the status word change nothing.
- R11: A write to a counter in the same cycle as one of its events loads the written value. That event is not counted and does not set status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 16 | Byte offset of the write |
| wr_data | input | 64 | Write data; 32-bit registers use bits 31:0 |
| rd_addr | input | 16 | Byte offset of the combinational read |
| rd_data | output | 64 | Read data for `rd_addr` |
| evt_in | input | NUM_EVT (256) | Event lines, one per code value |
| irq | output | 1 | Level interrupt, OR of unmasked status bits |

## Verification
The bench builds the unit with its default parameters: sixteen 48-bit counters, eight-bit codes and 256 event lines. Because the counters are full width, the bench reaches a wrap by preloading a counter to a value just below all ones and then supplying one or two events. This exercises the wrap, the masked and unmasked interrupt, and a clear that lands in the same cycle as a wrap, all within a few cycles. The full register map, including the select packing of the second select word and the reserved counter bits, is compared against a behavioural model on every clock.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 64;

  localparam logic [ADDR_W-1:0] A_MASK = 16'h0804;
  localparam logic [ADDR_W-1:0] A_STAT = 16'h0808;
  localparam logic [ADDR_W-1:0] A_CLR  = 16'h080C;
  localparam logic [ADDR_W-1:0] A_CTRL = 16'h1E00;
  localparam logic [ADDR_W-1:0] A_ENA  = 16'h1E04;
  localparam logic [ADDR_W-1:0] A_SEL  = 16'h1E80;
  localparam logic [ADDR_W-1:0] A_CNT  = 16'h1F00;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] addr;
    logic [31:0]       data;
  } cfg_wr_t;
endpackage

// File: rtl/evt_cfg_regs.sv
module evt_cfg_regs
  import evt_pkg::*;
#(
  parameter int NUM_CNT = 16,
  parameter int CODE_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  cfg_wr_t                   wr,
  output logic                      gen_en,
  output logic [NUM_CNT-1:0]        ena_q,
  output logic [NUM_CNT-1:0]        mask_q,
  output logic [NUM_CNT*CODE_W-1:0] sel_q
);
  localparam int PER_WORD  = 32 / CODE_W;
  localparam int NUM_WORDS = (NUM_CNT + PER_WORD - 1) / PER_WORD;

  logic                      gen_d;
  logic [NUM_CNT-1:0]        ena_d, mask_d;
  logic [NUM_CNT*CODE_W-1:0] sel_d;
  logic                      cfg_we;

  always_comb begin
    gen_d  = gen_en;
    ena_d  = ena_q;
    mask_d = mask_q;
    sel_d  = sel_q;
    if (wr.en) begin
      if (wr.addr == A_CTRL) gen_d  = wr.data[0];
      if (wr.addr == A_ENA)  ena_d  = wr.data[NUM_CNT-1:0];
      if (wr.addr == A_MASK) mask_d = wr.data[NUM_CNT-1:0];
      for (int k = 0; k < NUM_WORDS; k++) begin
        if (wr.addr == A_SEL + ADDR_W'(4 * k)) begin
          for (int j = 0; j < PER_WORD; j++) begin
            if (k * PER_WORD + j < NUM_CNT)
              sel_d[(k*PER_WORD+j)*CODE_W +: CODE_W] = wr.data[j*CODE_W +: CODE_W];
          end
        end
      end
    end
  end

  assign cfg_we = wr.en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en <= 1'b0;
      ena_q  <= '0;
      mask_q <= '1;
      sel_q  <= '1;
    end else if (cfg_we) begin
      gen_en <= gen_d;
      ena_q  <= ena_d;
      mask_q <= mask_d;
      sel_q  <= sel_d;
    end
  end
endmodule

// File: rtl/evt_cnt_slice.sv
module evt_cnt_slice #(
  parameter int CNT_W   = 48,
  parameter int CODE_W  = 8,
  parameter int NUM_EVT = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               run,
  input  logic [CODE_W-1:0]  code,
  input  logic               ld,
  input  logic [CNT_W-1:0]   ld_val,
  output logic [CNT_W-1:0]   count,
  output logic               wrap
);
  localparam logic [CODE_W-1:0] CODE_NONE = '1;

  logic             hit;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  always_comb begin
    hit = 1'b0;
    if (run && (code != CODE_NONE) && (int'(code) < NUM_EVT))
      hit = evt_in[code];
  end

  assign wrap   = hit && !ld && (count == '1);
  assign cnt_ce = ld || hit;
  assign cnt_d  = ld ? ld_val : count + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_ce) count <= cnt_d;
  end
endmodule

// File: rtl/evt_ovf_status.sv
module evt_ovf_status #(
  parameter int NUM_CNT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] wrap,
  input  logic [NUM_CNT-1:0] clr,
  input  logic [NUM_CNT-1:0] mask,
  output logic [NUM_CNT-1:0] stat,
  output logic               irq
);
  logic [NUM_CNT-1:0] stat_d;
  logic               stat_ce;

  assign stat_d  = (stat & ~clr) | wrap;
  assign stat_ce = (|wrap) || (|clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat <= '0;
    else if (stat_ce) stat <= stat_d;
  end

  assign irq = |(stat & ~mask);
endmodule

// File: rtl/evt_counter_unit.sv
module evt_counter_unit
  import evt_pkg::*;
#(
  parameter int NUM_CNT = 16,
  parameter int CNT_W   = 48,
  parameter int CODE_W  = 8,
  parameter int NUM_EVT = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [15:0]        wr_addr,
  input  logic [63:0]        wr_data,
  input  logic [15:0]        rd_addr,
  output logic [63:0]        rd_data,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic               irq
);
  localparam int PER_WORD  = 32 / CODE_W;
  localparam int NUM_WORDS = (NUM_CNT + PER_WORD - 1) / PER_WORD;

  cfg_wr_t                   cfg_wr;
  logic                      gen_en;
  logic [NUM_CNT-1:0]        ena_q, mask_q, stat_q, wrap_vec, ld_vec, clr_bits;
  logic [NUM_CNT*CODE_W-1:0] sel_q;
  logic [NUM_CNT*CNT_W-1:0]  cnt_flat;

  assign cfg_wr.en   = wr_en;
  assign cfg_wr.addr = wr_addr;
  assign cfg_wr.data = wr_data[31:0];

  evt_cfg_regs #(.NUM_CNT(NUM_CNT), .CODE_W(CODE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .gen_en(gen_en),
    .ena_q(ena_q), .mask_q(mask_q), .sel_q(sel_q)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign ld_vec[i] = wr_en && (wr_addr == A_CNT + ADDR_W'(8 * i));
    evt_cnt_slice #(.CNT_W(CNT_W), .CODE_W(CODE_W), .NUM_EVT(NUM_EVT)) u_slice (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
      .run(gen_en && ena_q[i]),
      .code(sel_q[i*CODE_W +: CODE_W]),
      .ld(ld_vec[i]), .ld_val(wr_data[CNT_W-1:0]),
      .count(cnt_flat[i*CNT_W +: CNT_W]), .wrap(wrap_vec[i])
    );
  end

  assign clr_bits = (wr_en && wr_addr == A_CLR) ? wr_data[NUM_CNT-1:0] : '0;

  evt_ovf_status #(.NUM_CNT(NUM_CNT)) u_stat (
    .clk(clk), .rst_n(rst_n), .wrap(wrap_vec), .clr(clr_bits),
    .mask(mask_q), .stat(stat_q), .irq(irq)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CTRL) rd_data[0] = gen_en;
    if (rd_addr == A_ENA)  rd_data[NUM_CNT-1:0] = ena_q;
    if (rd_addr == A_MASK) rd_data[NUM_CNT-1:0] = mask_q;
    if (rd_addr == A_STAT) rd_data[NUM_CNT-1:0] = stat_q;
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (rd_addr == A_SEL + ADDR_W'(4 * k)) begin
        for (int j = 0; j < PER_WORD; j++) begin
          if (k * PER_WORD + j < NUM_CNT)
            rd_data[j*CODE_W +: CODE_W] = sel_q[(k*PER_WORD+j)*CODE_W +: CODE_W];
        end
      end
    end
    for (int i = 0; i < NUM_CNT; i++) begin
      if (rd_addr == A_CNT + ADDR_W'(8 * i))
        rd_data[CNT_W-1:0] = cnt_flat[i*CNT_W +: CNT_W];
    end
  end
endmodule

// File: rtl/evt_counter_unit_chk.sv
module evt_counter_unit_chk
  import evt_pkg::*;
#(
  parameter int NUM_CNT = 16,
  parameter int CNT_W   = 48
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     gen_en,
  input logic                     wr_en,
  input logic [15:0]              rd_addr,
  input logic [63:0]              rd_data,
  input logic                     irq,
  input logic [NUM_CNT-1:0]       stat,
  input logic [NUM_CNT-1:0]       mask,
  input logic [NUM_CNT-1:0]       wrap,
  input logic [NUM_CNT-1:0]       clr_bits,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);
  logic in_cnt_range;
  assign in_cnt_range = (rd_addr >= A_CNT) && (rd_addr < A_CNT + ADDR_W'(8 * NUM_CNT));

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_cnt_range |-> ((rd_data >> CNT_W) == 64'd0)); // R2

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en && !wr_en) |=> $stable(cnt_flat)); // R4

  AST_STAT_FROM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(wrap)) == '0)); // R7

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_bits & ~wrap) != '0) |=> ((stat & $past(clr_bits & ~wrap)) == '0)); // R8

  AST_WRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap) |=> ((stat & $past(wrap)) == $past(wrap))); // R8

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq); // R9
endmodule

bind evt_counter_unit evt_counter_unit_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .wr_en(wr_en),
  .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .stat(stat_q),
  .mask(mask_q), .wrap(wrap_vec), .clr_bits(clr_bits), .cnt_flat(cnt_flat)
);

// File: tb/evt_counter_unit_bench.sv
`timescale 1ns/100ps
module evt_counter_unit_bench;
  localparam longint unsigned CMAX = 64'h0000_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [63:0] wr_data;
  logic [15:0] rd_addr;
  logic [63:0] rd_data;
  logic [255:0] evt_in;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  evt_counter_unit u_evt_counter_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_in(evt_in), .irq(irq)
  );

  // behavioural reference model
  longint unsigned m_cnt [16];
  bit [7:0]        m_sel [16];
  bit [15:0]       m_ena, m_mask, m_stat, m_wrap;
  bit              m_gen;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_cnt[i] = 0; m_sel[i] = 8'hFF; end
      m_ena = 0; m_mask = 16'hFFFF; m_stat = 0; m_gen = 0;
    end else begin
      m_wrap = 0;
      for (int i = 0; i < 16; i++) begin
        bit inc, ld;
        inc = m_gen && m_ena[i] && (m_sel[i] != 8'hFF) && evt_in[m_sel[i]];
        ld  = wr_en && (wr_addr == 16'h1F00 + 16'(8 * i));
        if (ld) m_cnt[i] = wr_data & CMAX;
        else if (inc) begin
          if (m_cnt[i] == CMAX) begin m_cnt[i] = 0; m_wrap[i] = 1; end
          else m_cnt[i] = m_cnt[i] + 1;
        end
      end
      if (wr_en) begin
        if (wr_addr == 16'h1E00) m_gen = wr_data[0];
        if (wr_addr == 16'h1E04) m_ena = wr_data[15:0];
        if (wr_addr == 16'h0804) m_mask = wr_data[15:0];
        if (wr_addr == 16'h080C) m_stat = m_stat & ~wr_data[15:0];
        for (int k = 0; k < 4; k++)
          if (wr_addr == 16'h1E80 + 16'(4 * k))
            for (int j = 0; j < 4; j++) m_sel[4*k+j] = wr_data[8*j +: 8];
      end
      m_stat = m_stat | m_wrap;
    end
  end

  function automatic logic [63:0] mread(logic [15:0] a);
    logic [63:0] v = 0;
    if (a == 16'h1E00) v[0] = m_gen;
    if (a == 16'h1E04) v[15:0] = m_ena;
    if (a == 16'h0804) v[15:0] = m_mask;
    if (a == 16'h0808) v[15:0] = m_stat;
    for (int k = 0; k < 4; k++)
      if (a == 16'h1E80 + 16'(4 * k))
        for (int j = 0; j < 4; j++) v[8*j +: 8] = m_sel[4*k+j];
    for (int i = 0; i < 16; i++)
      if (a == 16'h1F00 + 16'(8 * i)) v = m_cnt[i];
    return v;
  endfunction

  function automatic string area_tag(logic [15:0] a);
    if (a >= 16'h1F00 && a < 16'h1F80) return "R2";
    if (a >= 16'h1E80 && a < 16'h1E90) return "R3";
    if (a == 16'h1E00) return "R4";
    if (a == 16'h1E04) return "R5";
    if (a == 16'h0808) return "R7";
    if (a == 16'h0804) return "R9";
    return "R10";
  endfunction

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rd_data !== mread(rd_addr)) begin
        errors++;
        $display("FAIL %s model rd@%h actual=%h expected=%h", area_tag(rd_addr), rd_addr, rd_data, mread(rd_addr));
      end
      checks++;
      if (irq !== |(m_stat & ~m_mask)) begin
        errors++;
        $display("FAIL R9 model irq actual=%0b expected=%0b", irq, |(m_stat & ~m_mask));
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic expect_rd(input logic [15:0] a, input logic [63:0] exp, input string tag);
    step();
    rd_addr = a; #0.5;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s rd@%h actual=%h expected=%h", tag, a, rd_data, exp);
    end
  endtask

  task automatic expect_irq(input logic exp, input string tag);
    step(); #0.5;
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, exp);
    end
  endtask

  task automatic pulse(input int code, input int n);
    evt_in[code] = 1'b1;
    repeat (n) step();
    evt_in[code] = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; evt_in = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    expect_rd(16'h1E00, 64'h0, "R1");
    expect_rd(16'h1E04, 64'h0, "R1");
    expect_rd(16'h0804, 64'hFFFF, "R1");
    expect_rd(16'h0808, 64'h0, "R1");
    expect_rd(16'h1E80, 64'hFFFF_FFFF, "R1");
    expect_rd(16'h1F28, 64'h0, "R1");
    expect_irq(1'b0, "R1");

    // R2 reserved upper bits
    wr(16'h1F18, 64'hABCD_0000_1234_5678);
    expect_rd(16'h1F18, 64'h0000_0000_1234_5678, "R2");

    // R3 select packing
    wr(16'h1E80, 64'hFFFF_1005);
    wr(16'h1E84, 64'hFFC8_FFFF);
    expect_rd(16'h1E84, 64'hFFC8_FFFF, "R3");
    wr(16'h1E04, 64'h00C3);

    // R4 global run off
    evt_in[8'h05] = 1; evt_in[8'h10] = 1; evt_in[8'hC8] = 1; evt_in[8'hFF] = 1;
    repeat (4) step();
    evt_in = '0;
    expect_rd(16'h1F00, 64'h0, "R4");
    expect_rd(16'h1F30, 64'h0, "R4");

    // R3 counting
    wr(16'h1E00, 64'h1);
    pulse(8'h05, 3);
    expect_rd(16'h1F00, 64'd3, "R3");
    expect_rd(16'h1F08, 64'd0, "R3");
    pulse(8'hC8, 2);
    expect_rd(16'h1F30, 64'd2, "R3");

    // R6 no-event code
    pulse(8'hFF, 3);
    expect_rd(16'h1F38, 64'd0, "R6");

    // R5 per-counter enable
    wr(16'h1E04, 64'h00C2);
    pulse(8'h05, 2);
    expect_rd(16'h1F00, 64'd3, "R5");

    // R7 wrap with mask set
    wr(16'h1F08, 64'h0000_FFFF_FFFF_FFFE);
    pulse(8'h10, 2);
    expect_rd(16'h1F08, 64'd0, "R7");
    expect_rd(16'h0808, 64'h2, "R7");
    expect_irq(1'b0, "R9");

    // R9 unmask
    wr(16'h0804, 64'hFFFD);
    expect_irq(1'b1, "R9");

    // R8 clear semantics
    wr(16'h080C, 64'h0);
    expect_rd(16'h0808, 64'h2, "R8");
    wr(16'h080C, 64'h2);
    expect_rd(16'h0808, 64'h0, "R8");
    expect_irq(1'b0, "R8");

    // R8 wrap beats clear in the same cycle
    wr(16'h1F08, 64'h0000_FFFF_FFFF_FFFF);
    evt_in[8'h10] = 1;
    wr(16'h080C, 64'h2);
    evt_in[8'h10] = 0;
    expect_rd(16'h0808, 64'h2, "R8");
    expect_rd(16'h1F08, 64'h0, "R8");
    wr(16'h080C, 64'h2);

    // R10 unmapped offsets and status writes
    wr(16'h1000, 64'hFFFF_FFFF_FFFF_FFFF);
    expect_rd(16'h1000, 64'h0, "R10");
    expect_rd(16'h1E08, 64'h0, "R10");
    expect_rd(16'h080C, 64'h0, "R10");
    wr(16'h0808, 64'hFFFF);
    expect_rd(16'h0808, 64'h0, "R10");

    // R11 write beats a same-cycle event
    wr(16'h1E04, 64'h00C3);
    evt_in[8'h05] = 1;
    wr(16'h1F00, 64'd100);
    evt_in[8'h05] = 0;
    expect_rd(16'h1F00, 64'd100, "R11");

    repeat (2) step();
    finish_run();
  end
endmodule